// File: doc/BRIEF.md
# Split-Register Countdown Event Timer

This block is a 32-bit down-counter used by a network controller to time events chosen by software. Software reaches the count through two 16-bit read/write halves: the low half holds count bits 15:0 and the high half holds bits 31:16. Writing a half changes only those 16 bits. A read returns the live value of the selected half, and reads are valid while the timer runs.

Two command pulses control the timer. One starts it and one halts it. While it runs, the count drops by one on each cycle in which the tick enable is high. The tick enable stands for the transmit-clock rate and is one system-clock cycle wide. When the count passes from zero to all ones, a sticky status bit is set and the count carries on downward. The interrupt output is that status bit gated by a mask input. Writing 1 to the clear input drops the status bit. A hardware reset or a software reset halts the timer and leaves the count as it was.

Top module: `evt_timer_top`

## Requirements
- R1: While `rst` or `sw_rst` is high at a clock edge, `running` and `irq_status` are 0 after that edge.
- R2: A write with `wr_en`=1 loads `wr_data` into the half chosen by `wr_sel` (0 = bits 15:0, 1 = bits 31:16) at the next edge. The other half is not changed by the write. `rd_data` shows, without delay, the live half chosen by `rd_sel` (0 = low, 1 = high).
- R3: While `running` is 1 and no reset is high, each edge with `tick_en`=1 lowers the 32-bit count by exactly one. An edge with `tick_en`=0, or an edge with `running`=0, leaves the count unchanged.
- R4: A `cmd_start` pulse sets `running` at the next edge. A `cmd_stop` pulse clears it at the next edge. When both are high in the same cycle, stop wins. The decrement on the edge that takes the command follows the old `running` value.
- R5: A decrement from 0000_0000h, with no write in the same cycle, produces FFFF_FFFFh and sets `irq_status`. The count goes on decrementing after the wrap.
- R6: `irq` equals `irq_status` AND `irq_mask` in the same cycle. With the mask at 0, the status bit is still recorded.
- R7: `irq_clr`=1 clears `irq_status` at the next edge. A wrap in the same cycle wins, and the bit stays 1.
- R8: A write in a decrementing cycle overrides the decrement for the written half only. The other half takes its value from the 32-bit decrement. Such a cycle sets no wrap status.
- R9: A reset in a cycle blocks that cycle's decrement. The count keeps its value through and after hardware reset and software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset pulse, synchronous, active high |
| tick_en | input | 1 | One-cycle tick at the transmit-clock rate |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| wr_en | input | 1 | Write strobe for a count half |
| wr_sel | input | 1 | Half selected for writing (0 low, 1 high) |
| wr_data | input | 16 | Value written to the selected half |
| rd_sel | input | 1 | Half selected for reading (0 low, 1 high) |
| rd_data | output | 16 | Live value of the selected half |
| irq_mask | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-1-to-clear for the status bit |
| running | output | 1 | Timer run state |
| irq_status | output | 1 | Sticky wrap status |
| irq | output | 1 | Masked interrupt request |

## Verification
The count, `running` and `irq_status` are registered. Each of them shows the effect of a stimulus one rising edge after the cycle in which the stimulus is driven. `rd_data` and `irq` are combinational from the registers and from `rd_sel` and `irq_mask` in the current cycle. The bench drives inputs on the falling edge and lets its behavioural model take one step on the rising edge. It compares every output on the next falling edge, so each result is sampled exactly one edge after its cause. `rd_sel` alternates from cycle to cycle, so both halves are compared against the model as the count moves.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int CNT_W_DEF  = 32;
    localparam int HALF_W_DEF = 16;

    // Run-control request bundle
    typedef struct packed {
        logic start;
        logic stop;
        logic halt;
    } run_cmd_t;

    // Next state of the sticky status bit.
    // Reset clears it, a wrap sets it, and a set beats a clear in the same cycle.
    function automatic logic status_next(input logic cur, input logic halt,
                                         input logic wrap, input logic clr);
        if (halt)      return 1'b0;
        else if (wrap) return 1'b1;
        else if (clr)  return 1'b0;
        else           return cur;
    endfunction

    // Next run state. Reset or stop wins over start.
    function automatic logic run_next(input logic cur, input run_cmd_t c);
        if (c.halt || c.stop) return 1'b0;
        else if (c.start)     return 1'b1;
        else                  return cur;
    endfunction
endpackage

// File: rtl/gpt_run_ctrl.sv
module gpt_run_ctrl
    import gpt_pkg::*;
(
    input  logic     clk,
    input  run_cmd_t cmd,
    output logic     run_q
);
    always_ff @(posedge clk) begin
        run_q <= run_next(run_q, cmd);
    end
endmodule

// File: rtl/gpt_count.sv
module gpt_count #(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16,
    localparam int NUM_HALVES = CNT_W / HALF_W,
    localparam int SEL_W = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
    input  logic              clk,
    input  logic              dec_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              wrap
);
    logic [CNT_W-1:0]  dec_val;
    logic [HALF_W-1:0] half_q [NUM_HALVES];

    // 32-bit decrement. Every half follows it unless that half is written.
    assign dec_val = dec_en ? (cnt_q - 1'b1) : cnt_q;

    // A wrap counts only when no write interferes in the same cycle.
    assign wrap = dec_en && (cnt_q == '0) && !wr_en;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(h));
        // No reset: the count survives hardware and software reset.
        always_ff @(posedge clk) begin
            if (hit) half_q[h] <= wr_data;
            else     half_q[h] <= dec_val[h*HALF_W +: HALF_W];
        end
        assign cnt_q[h*HALF_W +: HALF_W] = half_q[h];
    end

    always_comb begin
        rd_data = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (rd_sel == SEL_W'(h)) rd_data = half_q[h];
        end
    end
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq
    import gpt_pkg::*;
(
    input  logic clk,
    input  logic halt,
    input  logic wrap,
    input  logic clr,
    input  logic mask,
    output logic status_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        status_q <= status_next(status_q, halt, wrap, clr);
    end

    assign irq = status_q & mask;
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
    import gpt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int HALF_W = HALF_W_DEF,
    localparam int NUM_HALVES = CNT_W / HALF_W,
    localparam int SEL_W = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              tick_en,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HALF_W-1:0] rd_data,
    input  logic              irq_mask,
    input  logic              irq_clr,
    output logic              running,
    output logic              irq_status,
    output logic              irq
);
    logic             halt;
    logic             dec_en;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    run_cmd_t         cmd;

    assign halt   = rst | sw_rst;
    assign cmd    = '{start: cmd_start, stop: cmd_stop, halt: halt};
    assign dec_en = running & tick_en & ~halt;

    gpt_run_ctrl u_run (
        .clk   (clk),
        .cmd   (cmd),
        .run_q (running)
    );

    gpt_count #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_count (
        .clk     (clk),
        .dec_en  (dec_en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .cnt_q   (cnt_q),
        .wrap    (wrap)
    );

    gpt_irq u_irq (
        .clk      (clk),
        .halt     (halt),
        .wrap     (wrap),
        .clr      (irq_clr),
        .mask     (irq_mask),
        .status_q (irq_status),
        .irq      (irq)
    );
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_rst,
    input logic             tick_en,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic             wr_en,
    input logic             irq_clr,
    input logic             irq_mask,
    input logic             running,
    input logic             irq_status,
    input logic             irq,
    input logic [CNT_W-1:0] cnt
);
    logic quiet;
    assign quiet = !wr_en && !rst && !sw_rst;

    assert_reset_halts_R1: assert property (@(posedge clk)
        (rst || sw_rst) |=> (!running && !irq_status));

    assert_dec_one_R3: assert property (@(posedge clk) disable iff (rst)
        (running && tick_en && quiet) |=> (cnt == $past(cnt) - 1'b1));

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_en) |=> $stable(cnt));

    assert_stop_wins_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> !running);

    assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (running && tick_en && quiet && cnt == '0) |=> (irq_status && cnt == '1));

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (irq |-> (irq_status && irq_mask)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !(running && tick_en && quiet && cnt == '0)) |=> !irq_status);

    assert_reset_keeps_R9: assert property (@(posedge clk)
        ((rst || sw_rst) && !wr_en) |=> $stable(cnt));
endmodule

bind evt_timer_top gpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_rst     (sw_rst),
    .tick_en    (tick_en),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .wr_en      (wr_en),
    .irq_clr    (irq_clr),
    .irq_mask   (irq_mask),
    .running    (running),
    .irq_status (irq_status),
    .irq        (irq),
    .cnt        (cnt_q)
);

// File: tb/evt_timer_top_test.sv
`timescale 1ns/1ps
module evt_timer_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b0, sw_rst = 1'b0, tick_en = 1'b0;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0, irq_mask = 1'b0, irq_clr = 1'b0;
    logic [15:0] rd_data;
    logic        running, irq_status, irq;

    always #5 clk = ~clk;

    evt_timer_top uut (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .tick_en(tick_en),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .running(running),
        .irq_status(irq_status), .irq(irq)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // Behavioural reference state
    longint m_cnt = 0;
    bit m_lo_ok = 0, m_hi_ok = 0, m_run = 0, m_stat = 0;

    // Stimulus for the next cycle
    bit b_st, b_sp, b_tk, b_we, b_sel, b_clr, b_msk, b_sr, b_hr;
    logic [15:0] b_d;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        bit halt, dec, wrap;
        longint nx;
        rst = b_hr; sw_rst = b_sr; tick_en = b_tk; cmd_start = b_st; cmd_stop = b_sp;
        wr_en = b_we; wr_sel = b_sel; wr_data = b_d; irq_clr = b_clr; irq_mask = b_msk;
        rd_sel = ~rd_sel;
        @(posedge clk);
        halt = b_hr || b_sr;
        dec  = m_run && b_tk && !halt;
        nx   = dec ? ((m_cnt - 1) & 64'hFFFF_FFFF) : m_cnt;
        if (b_we) begin
            if (b_sel) begin nx = (nx & 64'h0000_FFFF) | (longint'(b_d) << 16); m_hi_ok = 1; end
            else       begin nx = (nx & 64'hFFFF_0000) | longint'(b_d); m_lo_ok = 1; end
        end
        wrap = dec && (m_cnt == 0) && !b_we;
        if (halt) m_stat = 0; else if (wrap) m_stat = 1; else if (b_clr) m_stat = 0;
        if (halt || b_sp) m_run = 0; else if (b_st) m_run = 1;
        m_cnt = nx;
        @(negedge clk);
        check(tag, "running", running, m_run);
        check(tag, "irq_status", irq_status, m_stat);
        check(tag, "irq", irq, m_stat && b_msk);
        if (rd_sel ? m_hi_ok : m_lo_ok)
            check(tag, "rd_data", rd_data, rd_sel ? (m_cnt >> 16) & 16'hFFFF : m_cnt & 16'hFFFF);
        b_st = 0; b_sp = 0; b_we = 0; b_clr = 0; b_sr = 0; b_hr = 0;
    endtask

    task automatic wr(input bit sel, input logic [15:0] d, input string tag);
        b_we = 1; b_sel = sel; b_d = d; cyc(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        b_tk = 0; b_msk = 0; b_d = '0;
        b_st = 0; b_sp = 0; b_we = 0; b_sel = 0; b_clr = 0; b_sr = 0; b_hr = 0;
        @(negedge clk);
        b_hr = 1; cyc("R1");
        b_hr = 1; cyc("R1");
        wr(0, 16'h0003, "R2");
        wr(1, 16'h0000, "R2");
        b_tk = 1; cyc("R3"); cyc("R3");          // halted: ticks ignored
        b_st = 1; cyc("R4");                      // start; no decrement yet
        for (int i = 0; i < 6; i++) begin b_tk = (i % 2 == 0); cyc("R3"); end
        b_tk = 1; cyc("R5");                      // wrap with mask low
        cyc("R5");                                // keeps decrementing
        b_tk = 0; b_msk = 1; cyc("R6");
        b_clr = 1; cyc("R7");
        wr(0, 16'h0000, "R2");
        wr(1, 16'h0000, "R2");
        b_tk = 1; b_clr = 1; cyc("R7");           // wrap beats clear
        b_tk = 0; b_clr = 1; cyc("R7");
        b_tk = 1; b_sp = 1; cyc("R4");
        cyc("R4");
        b_st = 1; b_sp = 1; cyc("R4");            // stop wins
        b_tk = 0;
        wr(0, 16'h0000, "R8");
        wr(1, 16'h0001, "R8");
        b_st = 1; cyc("R8");
        b_tk = 1; wr(0, 16'h0005, "R8");          // -> 0000_0005
        wr(1, 16'h00AB, "R8");                    // -> 00AB_0004
        cyc("R8"); cyc("R8");
        b_sr = 1; cyc("R9");                      // frozen, halted
        cyc("R9"); cyc("R9");
        b_st = 1; cyc("R9");
        cyc("R9");
        b_hr = 1; cyc("R9");
        cyc("R9"); cyc("R9");
        // Mixed traffic
        seed = 32'h1234_5678;
        b_st = 1; cyc("R3");
        for (int i = 0; i < 400; i++) begin
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
            b_tk  = seed[0] | seed[1];
            b_st  = (seed[7:4] == 4'h3);
            b_sp  = (seed[7:4] == 4'h9);
            b_clr = (seed[11:8] == 4'h2);
            b_msk = seed[12];
            b_sr  = (seed[19:14] == 6'h11);
            if (seed[23:20] == 4'h5) begin b_we = 1; b_sel = seed[24]; b_d = {12'h000, seed[27:24]}; end
            cyc("R3");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule